// File: doc/BRIEF.md
# USB IN Endpoint Response Selector

This block picks the answer a USB device gives to an IN token on any of its eight endpoints. When the token strobe arrives, it reads the FIFO fill level and the maximum packet size of the addressed endpoint. It also reads that endpoint's "transfer in progress" control bit, which firmware holds high while it is still loading a transfer. From these it registers one of four responses, together with the payload length: a full packet, a short packet, a zero-length packet or a NAK.

An endpoint in the busy state never sends a partial or empty packet. If its FIFO holds less than one maximum packet, it answers with a NAK. An endpoint in the done state sends whatever it holds, and that short or empty packet closes the transfer.

Closing a transfer has two effects. It sets a sticky end-of-transfer flag, which firmware clears by writing one. It also returns the endpoint to the busy state, so that an empty FIFO answers the next token with a NAK instead of a stray zero-length packet. The token decoder, CRC, PHY and FIFO storage sit outside this block; only the FIFO occupancy counts come in.

Top module: `usbInRespSel`

## Requirements
- R1: Each of the eight endpoints has its own busy bit, visible on `busyState`. A one in `busySet` sets that bit, and a one in `busyClr` clears it. If both are written for the same endpoint in one cycle, set wins, and writes to one endpoint leave the others unchanged.
- R2: While reset is asserted, and right after it, `busyState` and `eotStatus` are all zero and `respValid` is low.
- R3: If the count of the addressed endpoint is greater than or equal to its maximum packet size, the response is DATA_FULL (code 1) with `respBytes` equal to the maximum packet size. This holds whatever the busy bit is.
- R4: If the endpoint is busy and its count is below the maximum, the response is NAK (code 0) with `respBytes` of zero.
- R5: If the endpoint is done and its count is between one and the maximum minus one, the response is DATA_SHORT (code 2) with `respBytes` equal to the count.
- R6: If the endpoint is done and its count is zero, the response is ZLP (code 3) with `respBytes` of zero. A busy endpoint never gives a ZLP.
- R7: The response appears on the clock edge that samples `tokenValid`. `respValid` is high for exactly one cycle per token, and `respEp` echoes the token's endpoint.
- R8: A DATA_SHORT or ZLP response sets that endpoint's `eotStatus` bit. The bit stays set until a one is written to the matching `eotClr` bit. A new terminating response in the same cycle as the clear leaves the bit set, and clearing one endpoint leaves the others unchanged.
- R9: A DATA_SHORT or ZLP response sets that endpoint's busy bit, overriding a firmware clear in the same cycle. A following token on the now-empty endpoint therefore gets a NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tokenValid | input | 1 | One-cycle strobe for an IN token |
| tokenEp | input | EP_W | Endpoint addressed by the token |
| fifoCount | input | NUM_EP*CNT_W | Per-endpoint FIFO byte counts, endpoint i at bits i*CNT_W upward |
| maxPkt | input | NUM_EP*CNT_W | Per-endpoint maximum packet sizes, same layout |
| busySet | input | NUM_EP | Write-one to set busy bits |
| busyClr | input | NUM_EP | Write-one to clear busy bits |
| eotClr | input | NUM_EP | Write-one to clear end-of-transfer flags |
| respValid | output | 1 | Response valid pulse |
| respCode | output | 2 | 0 NAK, 1 DATA_FULL, 2 DATA_SHORT, 3 ZLP |
| respBytes | output | CNT_W | Payload length of the response |
| respEp | output | EP_W | Endpoint the response belongs to |
| busyState | output | NUM_EP | Current busy bits |
| eotStatus | output | NUM_EP | Sticky end-of-transfer flags |

## Verification
The bench builds the block with eight endpoints and 7-bit counts. At that width a full-scale count of 127 against a maximum of 127 is reachable, and so are the one-below-maximum and one-byte cases against maxima of 8 and 64. The endpoints that are not addressed carry a different count and maximum, so a wrong endpoint select shows up in the results. Directed sequences cover these cases:
- the automatic return to busy after a terminating packet, and the NAK that follows;
- a firmware clear that collides with that automatic set;
- a flag clear that collides with a new terminating packet.

// File: rtl/usbInRespPkg.sv
package usbInRespPkg;
  typedef enum logic [1:0] {
    RESP_NAK   = 2'd0,
    RESP_FULL  = 2'd1,
    RESP_SHORT = 2'd2,
    RESP_ZLP   = 2'd3
  } respCode_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic      load;
    respCode_e code;
  } respStrobe_t;
endpackage

// File: rtl/usbInRespCtrl.sv
module usbInRespCtrl
  import usbInRespPkg::*;
#(
  parameter int NUM_EP = 8,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokenValid,
  input  logic [EP_W-1:0]   tokenEp,
  input  logic              selFull,
  input  logic              selEmpty,
  input  logic [NUM_EP-1:0] busySet,
  input  logic [NUM_EP-1:0] busyClr,
  input  logic [NUM_EP-1:0] eotClr,
  output respStrobe_t       strobe,
  output logic [NUM_EP-1:0] busyState,
  output logic [NUM_EP-1:0] eotStatus
);
  logic [NUM_EP-1:0] busyReg, eotReg, termMask, busyNext, eotNext;
  logic              curBusy, term;

  assign curBusy = busyReg[tokenEp];
  // A short or empty packet from a done endpoint closes the transfer
  assign term    = tokenValid && !selFull && !curBusy;

  always_comb begin
    termMask = '0;
    if (term) termMask[tokenEp] = 1'b1;
  end

  always_comb begin
    strobe.load = tokenValid;
    if (selFull)       strobe.code = RESP_FULL;
    else if (curBusy)  strobe.code = RESP_NAK;
    else if (selEmpty) strobe.code = RESP_ZLP;
    else               strobe.code = RESP_SHORT;
  end

  // set and auto-set dominate firmware clear
  assign busyNext = (busyReg & ~busyClr) | busySet | termMask;
  // new terminator dominates write-one-to-clear
  assign eotNext  = (eotReg & ~eotClr) | termMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyReg <= '0;
      eotReg  <= '0;
    end else begin
      busyReg <= busyNext;
      eotReg  <= eotNext;
    end
  end

  assign busyState = busyReg;
  assign eotStatus = eotReg;

  // A flag may only rise after a terminating response
  assert_eot_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((eotReg & ~$past(eotReg)) != '0) |-> $past(term));

  // The terminated endpoint is busy on the next cycle
  assert_auto_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(term) |-> busyReg[$past(tokenEp)]);

  // A set request always lands
  assert_set_lands_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(busySet) != '0 |-> ((busyReg & $past(busySet)) == $past(busySet)));
endmodule

// File: rtl/usbInRespDp.sv
module usbInRespDp
  import usbInRespPkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int CNT_W  = 10,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [EP_W-1:0]         tokenEp,
  input  logic [NUM_EP*CNT_W-1:0] fifoCount,
  input  logic [NUM_EP*CNT_W-1:0] maxPkt,
  input  respStrobe_t             strobe,
  output logic                    selFull,
  output logic                    selEmpty,
  output logic                    respValid,
  output logic [1:0]              respCode,
  output logic [CNT_W-1:0]        respBytes,
  output logic [EP_W-1:0]         respEp
);
  logic [CNT_W-1:0] cntArr [NUM_EP];
  logic [CNT_W-1:0] maxArr [NUM_EP];
  logic [CNT_W-1:0] cntSel, maxSel, bytesNext;

  for (genvar i = 0; i < NUM_EP; i++) begin : gUnpack
    assign cntArr[i] = fifoCount[i*CNT_W +: CNT_W];
    assign maxArr[i] = maxPkt[i*CNT_W +: CNT_W];
  end

  assign cntSel   = cntArr[tokenEp];
  assign maxSel   = maxArr[tokenEp];
  assign selFull  = (cntSel >= maxSel);
  assign selEmpty = (cntSel == '0);

  always_comb begin
    case (strobe.code)
      RESP_FULL:  bytesNext = maxSel;
      RESP_SHORT: bytesNext = cntSel;
      default:    bytesNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respCode  <= 2'd0;
      respBytes <= '0;
      respEp    <= '0;
    end else begin
      respValid <= strobe.load;
      if (strobe.load) begin
        respCode  <= strobe.code;
        respBytes <= bytesNext;
        respEp    <= tokenEp;
      end
    end
  end

  assert_nak_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respCode == 2'd0) |-> respBytes == '0);

  assert_short_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respCode == 2'd2) |-> respBytes != '0);

  assert_full_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && selFull) |=> (respCode == 2'd1 && respBytes == $past(maxSel)));
endmodule

// File: rtl/usbInRespSel.sv
module usbInRespSel
  import usbInRespPkg::*;
#(
  parameter int NUM_EP = 8,
  parameter int CNT_W  = 10,
  localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tokenValid,
  input  logic [EP_W-1:0]         tokenEp,
  input  logic [NUM_EP*CNT_W-1:0] fifoCount,
  input  logic [NUM_EP*CNT_W-1:0] maxPkt,
  input  logic [NUM_EP-1:0]       busySet,
  input  logic [NUM_EP-1:0]       busyClr,
  input  logic [NUM_EP-1:0]       eotClr,
  output logic                    respValid,
  output logic [1:0]              respCode,
  output logic [CNT_W-1:0]        respBytes,
  output logic [EP_W-1:0]         respEp,
  output logic [NUM_EP-1:0]       busyState,
  output logic [NUM_EP-1:0]       eotStatus
);
  respStrobe_t strobe;
  logic        selFull, selEmpty;

  usbInRespCtrl #(.NUM_EP(NUM_EP)) uCtrl (
    .clk, .rstN, .tokenValid, .tokenEp, .selFull, .selEmpty,
    .busySet, .busyClr, .eotClr, .strobe, .busyState, .eotStatus
  );

  usbInRespDp #(.NUM_EP(NUM_EP), .CNT_W(CNT_W)) uDp (
    .clk, .rstN, .tokenEp, .fifoCount, .maxPkt, .strobe,
    .selFull, .selEmpty, .respValid, .respCode, .respBytes, .respEp
  );

  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(tokenValid));

  assert_no_busy_zlp_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tokenValid && busyState[tokenEp]) |=> respCode != 2'd3);
endmodule

// File: tb/sim_usbInRespSel.sv
module sim_usbInRespSel;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int CW = 7;
  localparam int WD_CYCLES = 20000;

  typedef struct packed {
    logic [2:0]    ep;
    logic [CW-1:0] cnt;
    logic [CW-1:0] mx;
    logic          busy;
    logic [1:0]    code;
    logic [CW-1:0] bytes;
    logic          eot;
    logic          busyAfter;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 7'd64,  7'd64,  1'b1, 2'd1, 7'd64,  1'b0, 1'b1},
    '{3'd1, 7'd100, 7'd64,  1'b0, 2'd1, 7'd64,  1'b0, 1'b0},
    '{3'd2, 7'd10,  7'd64,  1'b1, 2'd0, 7'd0,   1'b0, 1'b1},
    '{3'd3, 7'd10,  7'd64,  1'b0, 2'd2, 7'd10,  1'b1, 1'b1},
    '{3'd4, 7'd0,   7'd64,  1'b0, 2'd3, 7'd0,   1'b1, 1'b1},
    '{3'd5, 7'd0,   7'd8,   1'b1, 2'd0, 7'd0,   1'b0, 1'b1},
    '{3'd6, 7'd63,  7'd64,  1'b0, 2'd2, 7'd63,  1'b1, 1'b1},
    '{3'd7, 7'd127, 7'd127, 1'b0, 2'd1, 7'd127, 1'b0, 1'b0},
    '{3'd7, 7'd1,   7'd8,   1'b0, 2'd2, 7'd1,   1'b1, 1'b1},
    '{3'd0, 7'd8,   7'd8,   1'b0, 2'd1, 7'd8,   1'b0, 1'b0},
    '{3'd5, 7'd7,   7'd8,   1'b1, 2'd0, 7'd0,   1'b0, 1'b1},
    '{3'd2, 7'd0,   7'd8,   1'b1, 2'd0, 7'd0,   1'b0, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tokenValid = 1'b0;
  logic [2:0]       tokenEp = '0;
  logic [NE*CW-1:0] fifoCount = '0;
  logic [NE*CW-1:0] maxPkt = '0;
  logic [NE-1:0]    busySet = '0, busyClr = '0, eotClr = '0;
  logic             respValid;
  logic [1:0]       respCode;
  logic [CW-1:0]    respBytes;
  logic [2:0]       respEp;
  logic [NE-1:0]    busyState, eotStatus;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usbInRespSel #(.NUM_EP(NE), .CNT_W(CW)) u0 (
    .clk, .rstN, .tokenValid, .tokenEp, .fifoCount, .maxPkt,
    .busySet, .busyClr, .eotClr, .respValid, .respCode, .respBytes,
    .respEp, .busyState, .eotStatus
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string codeTag(input logic [1:0] c);
    case (c)
      2'd1: return "R3 code";
      2'd0: return "R4 code";
      2'd2: return "R5 code";
      default: return "R6 code";
    endcase
  endfunction

  task automatic setFifo(input int ep, input int cnt, input int mx);
    for (int i = 0; i < NE; i++) begin
      fifoCount[i*CW +: CW] = (i == ep) ? CW'(cnt) : CW'(5);
      maxPkt[i*CW +: CW]    = (i == ep) ? CW'(mx)  : CW'(9);
    end
  endtask

  // token driven at a negedge; outputs sampled at the following negedge
  task automatic token(input int ep);
    @(negedge clk);
    tokenValid = 1'b1;
    tokenEp    = 3'(ep);
    @(negedge clk);
    tokenValid = 1'b0;
  endtask

  task automatic fwWrite(input logic [NE-1:0] s, input logic [NE-1:0] c,
                         input logic [NE-1:0] e);
    @(negedge clk);
    busySet = s; busyClr = c; eotClr = e;
    @(negedge clk);
    busySet = '0; busyClr = '0; eotClr = '0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R2: reset state
    repeat (3) @(negedge clk);
    chk("R2 busy during reset", busyState, 0);
    chk("R2 eot during reset", eotStatus, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R2 busy after reset", busyState, 0);
    chk("R2 eot after reset", eotStatus, 0);
    chk("R2 valid after reset", respValid, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      logic [NE-1:0] m = NE'(1) << t.ep;
      setFifo(t.ep, t.cnt, t.mx);
      fwWrite(t.busy ? m : '0, t.busy ? '0 : m, '1);
      token(t.ep);
      chk("R7 valid", respValid, 1);
      chk("R7 endpoint", respEp, t.ep);
      chk(codeTag(t.code), respCode, t.code);
      chk("R3/R5 length", respBytes, t.bytes);
      chk("R8 flag", eotStatus, t.eot ? m : 0);
      chk("R9 busy", busyState[t.ep], t.busyAfter);
      @(negedge clk);
      chk("R7 single pulse", respValid, 0);
    end

    // R1: set wins over clear; writes are per endpoint
    fwWrite('0, '1, '1);
    chk("R1 all clear", busyState, 0);
    fwWrite(8'b0000_0010, 8'b0000_0010, '0);
    chk("R1 set dominates", busyState, 8'b0000_0010);
    fwWrite(8'b0000_0100, '0, '0);
    chk("R1 independent set", busyState, 8'b0000_0110);
    fwWrite('0, 8'b0000_0010, '0);
    chk("R1 independent clear", busyState, 8'b0000_0100);

    // R9: ZLP then automatic busy gives NAK on the next empty token
    setFifo(3, 0, 16);
    token(3);
    chk("R6 zlp", respCode, 3);
    chk("R9 busy after zlp", busyState[3], 1);
    token(3);
    chk("R9 nak after zlp", respCode, 0);
    chk("R9 nak length", respBytes, 0);

    // R8: sticky flag, survives idle cycles
    repeat (3) @(negedge clk);
    chk("R8 sticky", eotStatus, 8'b0000_1000);
    fwWrite('0, '0, 8'b0000_0001);
    chk("R8 other clear no effect", eotStatus, 8'b0000_1000);
    fwWrite('0, '0, 8'b0000_1000);
    chk("R8 w1c", eotStatus, 0);

    // R9 and R8 collisions: terminator with firmware clear of busy and flag
    fwWrite('0, 8'b0100_0000, '0);
    fwWrite('0, '0, '0);
    setFifo(6, 3, 16);
    fwWrite('0, '0, '0);
    @(negedge clk);
    tokenValid = 1'b1; tokenEp = 3'd6;
    busyClr = 8'b0100_0000; eotClr = 8'b0100_0000;
    @(negedge clk);
    tokenValid = 1'b0; busyClr = '0; eotClr = '0;
    chk("R5 short with collision", respCode, 2);
    chk("R9 auto set beats clear", busyState[6], 1);
    chk("R8 new flag beats clear", eotStatus[6], 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule